// File: doc/BRIEF.md
# Four-Bit Selectable Logic and Arithmetic Slice

This block is a purely combinational four-bit slice that computes one of thirty-two functions of two operands. A four-bit select code and a mode bit choose the function. With the mode bit high, each result bit is a bitwise function of the matching operand bits, so the carry does not affect the result. With the mode bit low, the slice adds two operand-derived terms together with an optional carry. The data bits are active-high. The carry input and the carry output are active-low.

Wider datapaths are built from several slices. Each slice produces an active-low group generate and an active-low group propagate, which an external lookahead unit can combine. An equality flag is high when every result bit is one. In the subtract-minus-one function this flag shows that the two operands are equal. The slice contains no registers.

Top module: `alu4_slice`

## Requirements
- R1: With `logic_mode_i`=1, `sel_i` values 0 to 7 give F = ~A, ~(A|B), ~A&B, 0000, ~(A&B), ~B, A^B, A&~B, in that order of select value.
- R2: With `logic_mode_i`=1, `sel_i` values 8 to 15 give F = ~A|B, ~(A^B), B, A&B, 1111, A|~B, A|B, A, in that order of select value.
- R3: With `logic_mode_i`=0 and `carry_in_n_i`=1, `sel_i` values 0 to 7 give F as the low four bits of: A; A|B; A|~B; 15 (minus one); A+(A&~B); (A|B)+(A&~B); A+~B (A minus B minus 1); (A&~B)+15.
- R4: With `logic_mode_i`=0 and `carry_in_n_i`=1, `sel_i` values 8 to 15 give F as the low four bits of: A+(A&B); A+B; (A|~B)+(A&B); (A&B)+15; A+A; (A|B)+A; (A|~B)+A; A+15.
- R5: In arithmetic mode, driving `carry_in_n_i` low adds one to the sum of R3/R4 (select 6 then gives A minus B).
- R6: `carry_out_n_o` is low exactly when the five-bit sum of the selected R3/R4 terms plus the active carry-in is above 15. This holds in both modes.
- R7: In logic mode, `carry_in_n_i` has no effect on `f_o`.
- R8: `eq_o` is high exactly when `f_o` equals 1111.
- R9: `gen_n_o` is low exactly when the selected arithmetic sum carries out with no carry-in.
- R10: When `gen_n_o` is high, `prop_n_o` is low exactly when an active carry-in produces a carry-out.
- R11: In arithmetic mode, with select 6 and `carry_in_n_i`=1, `eq_o` is high exactly when A equals B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | Operand A |
| b_i | input | 4 | Operand B |
| sel_i | input | 4 | Function select code |
| logic_mode_i | input | 1 | 1 = bitwise logic, 0 = arithmetic |
| carry_in_n_i | input | 1 | Carry input, active-low |
| f_o | output | 4 | Result |
| carry_out_n_o | output | 1 | Carry output, active-low |
| gen_n_o | output | 1 | Group generate, active-low |
| prop_n_o | output | 1 | Group propagate, active-low |
| eq_o | output | 1 | High when every result bit is one |

## Verification
The assertions check several relations whenever an input changes:
- the equality flag always agrees with the result bits;
- an active group generate always forces a carry-out;
- an active group propagate always passes an active carry-in through to the carry-out;
- the plain add code and the subtract code always give the true operand sum and difference.

Only the bench's scenarios can show that the other thirty select/mode combinations follow their tables. The same holds for the exact carry-out values in each case, for the claim that the carry-in has no effect in logic mode, and for the boundary operands 0000 and 1111. The bench compares every output against a table-driven model over directed and seeded random vectors.

// File: rtl/alu_slice_pkg.sv
package alu_slice_pkg;

    localparam int SLICE_W = 4;

    typedef struct packed {
        logic [SLICE_W-1:0] f;
        logic               cout_n;
        logic               gen_n;
        logic               prop_n;
        logic               eq;
    } slice_res_t;

endpackage

// File: rtl/alu_bit_terms.sv
module alu_bit_terms #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   sel_i,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o
);
    // x: OR-style term, always covers A; y: AND-style term, always inside A
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign x_o[i] = a_i[i] | (b_i[i] & sel_i[0]) | (~b_i[i] & sel_i[1]);
        assign y_o[i] = (a_i[i] & ~b_i[i] & sel_i[2]) | (a_i[i] & b_i[i] & sel_i[3]);
    end
endmodule

// File: rtl/alu_carry_chain.sv
module alu_carry_chain #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W:0]   carry_o,
    output logic         grp_gen_o,
    output logic         grp_prop_o
);
    // y lies inside x per bit, so y acts as generate and x as propagate
    always_comb begin
        logic gen_acc;
        carry_o[0] = cin_i;
        gen_acc    = 1'b0;
        for (int i = 0; i < W; i++) begin
            carry_o[i+1] = y_i[i] | (x_i[i] & carry_o[i]);
            gen_acc      = y_i[i] | (x_i[i] & gen_acc);
        end
        grp_gen_o  = gen_acc;
        grp_prop_o = &x_i;
    end
endmodule

// File: rtl/alu_result_sel.sv
module alu_result_sel #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic [W-1:0] carry_i,
    input  logic         logic_mode_i,
    output logic [W-1:0] f_o
);
    logic [W-1:0] half_sum;
    assign half_sum = x_i ^ y_i;
    assign f_o = logic_mode_i ? ~half_sum : (half_sum ^ carry_i);
endmodule

// File: rtl/alu4_slice.sv
module alu4_slice
    import alu_slice_pkg::*;
#(
    parameter int W = SLICE_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [3:0]   sel_i,
    input  logic         logic_mode_i,
    input  logic         carry_in_n_i,
    output logic [W-1:0] f_o,
    output logic         carry_out_n_o,
    output logic         gen_n_o,
    output logic         prop_n_o,
    output logic         eq_o
);
    logic [W-1:0] x_term;
    logic [W-1:0] y_term;
    logic [W:0]   carry;
    logic         grp_gen;
    logic         grp_prop;
    logic [W-1:0] f_d;
    slice_res_t   res_d;

    alu_bit_terms #(.W(W)) u_terms (
        .a_i   (a_i),
        .b_i   (b_i),
        .sel_i (sel_i),
        .x_o   (x_term),
        .y_o   (y_term)
    );

    alu_carry_chain #(.W(W)) u_chain (
        .x_i        (x_term),
        .y_i        (y_term),
        .cin_i      (~carry_in_n_i),
        .carry_o    (carry),
        .grp_gen_o  (grp_gen),
        .grp_prop_o (grp_prop)
    );

    alu_result_sel #(.W(W)) u_result (
        .x_i          (x_term),
        .y_i          (y_term),
        .carry_i      (carry[W-1:0]),
        .logic_mode_i (logic_mode_i),
        .f_o          (f_d)
    );

    always_comb begin
        res_d        = '0;
        res_d.f      = f_d;
        res_d.cout_n = ~carry[W];
        res_d.gen_n  = ~grp_gen;
        res_d.prop_n = ~grp_prop;
        res_d.eq     = &f_d;
    end

    assign f_o           = res_d.f;
    assign carry_out_n_o = res_d.cout_n;
    assign gen_n_o       = res_d.gen_n;
    assign prop_n_o      = res_d.prop_n;
    assign eq_o          = res_d.eq;
endmodule

// File: rtl/alu4_slice_chk.sv
module alu4_slice_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [3:0]   sel_i,
    input logic         logic_mode_i,
    input logic         carry_in_n_i,
    input logic [W-1:0] f_o,
    input logic         carry_out_n_o,
    input logic         gen_n_o,
    input logic         prop_n_o,
    input logic         eq_o
);
    logic [W:0] add_ref;
    logic [W-1:0] sub_ref;
    assign add_ref = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ~carry_in_n_i};
    assign sub_ref = a_i - b_i;

    always_comb begin
        p_eq_all_ones_r8: assert (eq_o == (f_o == {W{1'b1}}));
        if (!gen_n_o)
            p_gen_forces_carry_r9: assert (!carry_out_n_o);
        if (!prop_n_o && !carry_in_n_i)
            p_prop_passes_carry_r10: assert (!carry_out_n_o);
        if (!logic_mode_i && sel_i == 4'd9)
            p_plain_add_r4: assert ({~carry_out_n_o, f_o} == add_ref);
        if (!logic_mode_i && sel_i == 4'd6 && !carry_in_n_i)
            p_true_sub_r5: assert (f_o == sub_ref);
        if (!logic_mode_i && sel_i == 4'd6 && carry_in_n_i)
            p_sub_equal_r11: assert (eq_o == (a_i == b_i));
        if (logic_mode_i && sel_i == 4'd3)
            p_logic_zero_r1: assert (f_o == '0);
    end
endmodule

bind alu4_slice alu4_slice_chk #(.W(W)) u_chk (
    .a_i           (a_i),
    .b_i           (b_i),
    .sel_i         (sel_i),
    .logic_mode_i  (logic_mode_i),
    .carry_in_n_i  (carry_in_n_i),
    .f_o           (f_o),
    .carry_out_n_o (carry_out_n_o),
    .gen_n_o       (gen_n_o),
    .prop_n_o      (prop_n_o),
    .eq_o          (eq_o)
);

// File: tb/test_alu4_slice.sv
module test_alu4_slice;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a, b, sel;
    logic       mode, cin_n;
    logic [3:0] f;
    logic       cout_n, gen_n, prop_n, eq;
    int         n_checks = 0;
    int         n_fails  = 0;
    bit         done     = 1'b0;

    always #4 clk = ~clk;

    alu4_slice i_alu4_slice (
        .a_i (a), .b_i (b), .sel_i (sel), .logic_mode_i (mode),
        .carry_in_n_i (cin_n), .f_o (f), .carry_out_n_o (cout_n),
        .gen_n_o (gen_n), .prop_n_o (prop_n), .eq_o (eq)
    );

    // five-bit arithmetic sum from the requirement tables (R3/R4/R5)
    function automatic logic [4:0] arith_ref(input logic [3:0] x, input logic [3:0] y,
                                             input logic [3:0] s, input logic c);
        logic [4:0] p, q;
        case (s)
            4'd0:  begin p = {1'b0, x};       q = 5'd0; end
            4'd1:  begin p = {1'b0, x | y};   q = 5'd0; end
            4'd2:  begin p = {1'b0, x | ~y};  q = 5'd0; end
            4'd3:  begin p = 5'd15;           q = 5'd0; end
            4'd4:  begin p = {1'b0, x};       q = {1'b0, x & ~y}; end
            4'd5:  begin p = {1'b0, x | y};   q = {1'b0, x & ~y}; end
            4'd6:  begin p = {1'b0, x};       q = {1'b0, ~y}; end
            4'd7:  begin p = {1'b0, x & ~y};  q = 5'd15; end
            4'd8:  begin p = {1'b0, x};       q = {1'b0, x & y}; end
            4'd9:  begin p = {1'b0, x};       q = {1'b0, y}; end
            4'd10: begin p = {1'b0, x | ~y};  q = {1'b0, x & y}; end
            4'd11: begin p = {1'b0, x & y};   q = 5'd15; end
            4'd12: begin p = {1'b0, x};       q = {1'b0, x}; end
            4'd13: begin p = {1'b0, x | y};   q = {1'b0, x}; end
            4'd14: begin p = {1'b0, x | ~y};  q = {1'b0, x}; end
            default: begin p = {1'b0, x};     q = 5'd15; end
        endcase
        return p + q + {4'd0, c};
    endfunction

    function automatic logic [3:0] logic_ref(input logic [3:0] x, input logic [3:0] y,
                                             input logic [3:0] s);
        case (s)
            4'd0:  return ~x;
            4'd1:  return ~(x | y);
            4'd2:  return ~x & y;
            4'd3:  return 4'h0;
            4'd4:  return ~(x & y);
            4'd5:  return ~y;
            4'd6:  return x ^ y;
            4'd7:  return x & ~y;
            4'd8:  return ~x | y;
            4'd9:  return ~(x ^ y);
            4'd10: return y;
            4'd11: return x & y;
            4'd12: return 4'hF;
            4'd13: return x | ~y;
            4'd14: return x | y;
            default: return x;
        endcase
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: sel=%0d m=%0b cin_n=%0b a=%h b=%h act=%h exp=%h",
                     req, sel, mode, cin_n, a, b, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] ta, input logic [3:0] tb, input logic [3:0] ts,
                         input logic tm, input logic tc);
        logic [4:0] s_now, s_nc, s_c;
        logic [3:0] f_exp;
        @(posedge clk);
        a = ta; b = tb; sel = ts; mode = tm; cin_n = tc;
        @(negedge clk);
        s_now = arith_ref(ta, tb, ts, ~tc);
        s_nc  = arith_ref(ta, tb, ts, 1'b0);
        s_c   = arith_ref(ta, tb, ts, 1'b1);
        f_exp = tm ? logic_ref(ta, tb, ts) : s_now[3:0];
        if (tm) begin
            if (ts < 4'd8) check("R1", {1'b0, f}, {1'b0, f_exp});
            else           check("R2", {1'b0, f}, {1'b0, f_exp});
        end else if (!tc)  check("R5", {1'b0, f}, {1'b0, f_exp});
        else if (ts < 4'd8) check("R3", {1'b0, f}, {1'b0, f_exp});
        else               check("R4", {1'b0, f}, {1'b0, f_exp});
        check("R6", {4'd0, cout_n}, {4'd0, ~s_now[4]});
        check("R8", {4'd0, eq}, {4'd0, f_exp == 4'hF});
        check("R9", {4'd0, gen_n}, {4'd0, ~s_nc[4]});
        if (!s_nc[4]) check("R10", {4'd0, prop_n}, {4'd0, ~s_c[4]});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : stim
        logic [3:0] f_hi;
        a = '0; b = '0; sel = '0; mode = 1'b1; cin_n = 1'b1;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // idle inputs: logic NOT A of zero is all ones
        check("R1", {1'b0, f}, 5'h0F);
        check("R8", {4'd0, eq}, 5'd1);
        // all selects and modes at the operand extremes
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 4; k++) begin
                apply(4'h0, 4'hF, 4'(s), 1'b1, 1'(k));
                apply(4'hF, 4'h0, 4'(s), 1'b0, 1'(k));
                apply(4'hF, 4'hF, 4'(s), 1'(k >> 1), 1'(k));
                apply(4'h0, 4'h0, 4'(s), 1'(k >> 1), 1'(k));
            end
        end
        // R11: equality through subtract-minus-one
        for (int v = 0; v < 16; v++) begin
            apply(4'(v), 4'(v), 4'd6, 1'b0, 1'b1);
            check("R11", {4'd0, eq}, 5'd1);
            apply(4'(v), 4'(v + 1), 4'd6, 1'b0, 1'b1);
            check("R11", {4'd0, eq}, 5'd0);
        end
        // R7: in logic mode, carry-in leaves result unchanged
        for (int s = 0; s < 16; s++) begin
            apply(4'h5, 4'hC, 4'(s), 1'b1, 1'b1);
            f_hi = f;
            apply(4'h5, 4'hC, 4'(s), 1'b1, 1'b0);
            check("R7", {1'b0, f}, {1'b0, f_hi});
        end
        // seeded random sweep
        void'($urandom(32'd2718));
        for (int i = 0; i < 6000; i++) begin
            logic [31:0] r;
            r = $urandom();
            apply(r[3:0], r[7:4], r[11:8], r[12], r[13]);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule